// File: doc/BRIEF.md
# Atomic Memory Request Responder

This block is a single-port memory target on a simple request bus. Each request names a command, a byte address, a size of one to eight bytes, write data, a compare value, a requester ID and three qualifiers: an instruction-fetch flag, a needs-response flag and a flag that says another cache is already answering. The backing store is a byte-addressed RAM inside the block. It covers `DEPTH` bytes starting at the parameter `BASE`.

Reads, writes and both swap flavours act on the store. A write takes effect only when an external reservation monitor grants it through `wr_allow`. A swap always returns the prior contents. A conditional swap writes only when the stored word equals the compare value. Invalidate/clean requests leave memory alone. Eviction notices are dropped silently. Per-requester statistics counters can be read through a select input. A sticky error flag records requests the block cannot serve.

Top module: `atomic_mem_target`

## Requirements
- R1: After reset, `rsp_valid` and `err_flag` are 0 and every statistics counter of every requester reads 0.
- R2: A read (command 0) returns `size` bytes little-endian: the byte at `addr+k` goes to `rsp_rdata[8k+7:8k]` and the bytes above `size` read as zero. The response is registered and appears on the cycle after the request.
- R3: A write (command 1) stores `size` bytes of `req_wdata` in the same lane order only when `wr_allow` is 1. With `wr_allow` at 0 memory and write counters stay unchanged, but the response is still given.
- R4: A plain swap (command 2) returns the old bytes and always writes the new data.
- R5: A conditional swap (command 3) returns the old bytes. It writes only when the old bytes equal the low `size` bytes of `req_cmp`. Only sizes 4 and 8 are allowed. Any other size sets the error flag, changes nothing and gives no response.
- R6: A request with `req_cache_resp` set is ignored entirely: no response, no memory or counter change, no error, even for an unknown command.
- R7: Clean-evict (command 5) and clean-writeback (command 6) produce no response, no memory change and no error.
- R8: Invalidate/clean (command 4) leaves memory unchanged and responds with all-zero data.
- R9: With `req_needs_resp` at 0 no response is given, but memory and counters are updated as usual.
- R10: For each requester, a read increments the read count and adds `size` to read bytes. An instruction-fetch read also adds `size` to fetch bytes. An allowed write increments the write count and adds `size` to written bytes. Either swap increments the other count.
- R11: Command 7 sets the sticky error flag and has no other effect. Only reset clears the flag.
- R12: An address below `BASE`, an access that ends past `BASE+DEPTH`, or a size of 0 or above 8 sets the error flag and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 3 | Command code (0 read, 1 write, 2 swap, 3 conditional swap, 4 invalidate/clean, 5 clean-evict, 6 clean-writeback, 7 unknown) |
| req_addr | input | AW | Byte address |
| req_size | input | 4 | Size in bytes |
| req_wdata | input | 64 | Write / swap data, byte k in bits 8k+7:8k |
| req_cmp | input | 64 | Compare value for conditional swap |
| req_id | input | IDW | Requester ID |
| req_ifetch | input | 1 | Instruction-fetch qualifier |
| req_needs_resp | input | 1 | Request wants a response |
| req_cache_resp | input | 1 | Another agent answers; ignore request |
| wr_allow | input | 1 | Reservation monitor grants the write |
| stat_sel | input | IDW | Requester whose counters are shown |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Response data |
| err_flag | output | 1 | Sticky error flag |
| stat_rd_cnt | output | CW | Read count of selected requester |
| stat_wr_cnt | output | CW | Write count of selected requester |
| stat_oth_cnt | output | CW | Swap count of selected requester |
| stat_rd_bytes | output | CW | Bytes read by selected requester |
| stat_wr_bytes | output | CW | Bytes written by selected requester |
| stat_if_bytes | output | CW | Fetch bytes of selected requester |

## Verification
Every result is due exactly one clock edge after the request is presented. This covers the response strobe and data, the error flag, the counters and the memory update, which the next read sees. The bench presents a request at a falling edge and samples all outputs at the next falling edge. At that point a single rising edge has passed. Before that edge the bench computes the expected response, flag and counters from its own byte model. Memory effects are checked through later reads.

// File: rtl/amt_pkg.sv
// Shared command codes and lane count for the atomic memory responder.
package amt_pkg;
    typedef enum logic [2:0] {
        CMD_READ    = 3'd0,
        CMD_WRITE   = 3'd1,
        CMD_SWAP    = 3'd2,
        CMD_CSWAP   = 3'd3,
        CMD_INVAL   = 3'd4,
        CMD_EVICT   = 3'd5,
        CMD_WBCLEAN = 3'd6,
        CMD_BAD     = 3'd7
    } amt_cmd_e;

    localparam int LANES = 8;
endpackage

// File: rtl/amt_store.sv
// Byte-addressed backing RAM. The read is combinational and gives the
// contents before this cycle's write. Lanes at or above size read as zero.
// Assumes DEPTH is a power of two, so offsets wrap inside the array.
module amt_store #(
    parameter int DEPTH = 64,
    localparam int OW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [OW-1:0] off,
    input  logic [3:0]    size,
    input  logic          wr_en,
    input  logic [63:0]   wdata,
    output logic [63:0]   rdata
);
    logic [7:0] mem [DEPTH];

    // Per-lane masked read of the old contents.
    for (genvar i = 0; i < amt_pkg::LANES; i++) begin : g_lane
        assign rdata[8*i +: 8] = (4'(i) < size) ? mem[off + OW'(i)] : 8'h00;
    end

    // Byte-lane write of the low size bytes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < amt_pkg::LANES; i++) begin
            if (wr_en && (4'(i) < size)) begin
                mem[off + OW'(i)] <= wdata[8*i +: 8];
            end
        end
    end
endmodule

// File: rtl/amt_decode.sv
// Request classifier. It checks the range and size, applies the drop rules
// and the write grant, compares for a conditional swap, and derives the
// memory, response, counter and error actions. Purely combinational.
module amt_decode #(
    parameter int AW    = 16,
    parameter int BASE  = 'h1000,
    parameter int DEPTH = 64,
    localparam int OW = $clog2(DEPTH)
) (
    input  logic          req_valid,
    input  logic [2:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_size,
    input  logic [63:0]   req_cmp,
    input  logic          req_needs_resp,
    input  logic          req_cache_resp,
    input  logic          wr_allow,
    input  logic [63:0]   old_data,
    output logic [OW-1:0] off,
    output logic          mem_wr,
    output logic          ret_old,
    output logic          resp,
    output logic          err_set,
    output logic          inc_rd,
    output logic          inc_wr,
    output logic          inc_oth
);
    import amt_pkg::*;

    amt_cmd_e    cmd;
    logic [AW:0] addr_x, base_x, rel, end_x;
    logic        lo_ok, hi_ok, size_ok, cs_ok, act, ok, match;
    logic [63:0] cmp_m;

    // Range and size qualification.
    always_comb begin
        addr_x  = {1'b0, req_addr};
        base_x  = (AW+1)'(BASE);
        rel     = addr_x - base_x;
        end_x   = rel + (AW+1)'(req_size);
        lo_ok   = addr_x >= base_x;
        hi_ok   = end_x <= (AW+1)'(DEPTH);
        size_ok = (req_size != 4'd0) && (req_size <= 4'd8);
        off     = rel[OW-1:0];
    end

    // Compare value masked to the conditional-swap width.
    always_comb begin
        unique case (req_size)
            4'd8:    cmp_m = req_cmp;
            4'd4:    cmp_m = {32'h0, req_cmp[31:0]};
            default: cmp_m = '0;
        endcase
        match = (old_data == cmp_m);
    end

    // Action decode.
    always_comb begin
        cmd     = amt_cmd_e'(req_cmd);
        act     = req_valid && !req_cache_resp &&
                  (cmd != CMD_EVICT) && (cmd != CMD_WBCLEAN);
        cs_ok   = (cmd != CMD_CSWAP) || (req_size == 4'd4) || (req_size == 4'd8);
        ok      = act && (cmd != CMD_BAD) && lo_ok && hi_ok && size_ok && cs_ok;
        err_set = act && !ok;
        mem_wr  = ok && (((cmd == CMD_WRITE) && wr_allow) || (cmd == CMD_SWAP) ||
                         ((cmd == CMD_CSWAP) && match));
        ret_old = ok && ((cmd == CMD_READ) || (cmd == CMD_SWAP) || (cmd == CMD_CSWAP));
        resp    = ok && req_needs_resp;
        inc_rd  = ok && (cmd == CMD_READ);
        inc_wr  = ok && (cmd == CMD_WRITE) && wr_allow;
        inc_oth = ok && ((cmd == CMD_SWAP) || (cmd == CMD_CSWAP));
    end
endmodule

// File: rtl/amt_stats.sv
// Per-requester statistics bank: three event counts and three byte sums for
// each ID. Counters wrap at CW bits. The select input picks one ID to show.
module amt_stats #(
    parameter int NREQ = 4,
    parameter int CW   = 16,
    localparam int IDW = $clog2(NREQ)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IDW-1:0] id,
    input  logic           inc_rd,
    input  logic           inc_wr,
    input  logic           inc_oth,
    input  logic           ifetch,
    input  logic [3:0]     size,
    input  logic [IDW-1:0] sel,
    output logic [CW-1:0]  rd_cnt,
    output logic [CW-1:0]  wr_cnt,
    output logic [CW-1:0]  oth_cnt,
    output logic [CW-1:0]  rd_bytes,
    output logic [CW-1:0]  wr_bytes,
    output logic [CW-1:0]  if_bytes
);
    logic [CW-1:0] c_rd [NREQ];
    logic [CW-1:0] c_wr [NREQ];
    logic [CW-1:0] c_ot [NREQ];
    logic [CW-1:0] b_rd [NREQ];
    logic [CW-1:0] b_wr [NREQ];
    logic [CW-1:0] b_if [NREQ];
    logic [CW-1:0] sz_x;

    assign sz_x = CW'(size);

    for (genvar r = 0; r < NREQ; r++) begin : g_req
        logic hit;
        assign hit = (id == IDW'(r));
        // Counter update for requester r.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c_rd[r] <= '0; c_wr[r] <= '0; c_ot[r] <= '0;
                b_rd[r] <= '0; b_wr[r] <= '0; b_if[r] <= '0;
            end else if (hit) begin
                if (inc_rd) begin
                    c_rd[r] <= c_rd[r] + 1'b1;
                    b_rd[r] <= b_rd[r] + sz_x;
                    if (ifetch) b_if[r] <= b_if[r] + sz_x;
                end
                if (inc_wr) begin
                    c_wr[r] <= c_wr[r] + 1'b1;
                    b_wr[r] <= b_wr[r] + sz_x;
                end
                if (inc_oth) c_ot[r] <= c_ot[r] + 1'b1;
            end
        end
    end

    // Readout mux for the selected requester.
    always_comb begin
        rd_cnt   = c_rd[sel];
        wr_cnt   = c_wr[sel];
        oth_cnt  = c_ot[sel];
        rd_bytes = b_rd[sel];
        wr_bytes = b_wr[sel];
        if_bytes = b_if[sel];
    end
endmodule

// File: rtl/atomic_mem_target.sv
// Atomic memory request responder top. It decodes each request and acts on
// the byte store in the same cycle, then registers the response and the
// sticky error flag. At most one request per cycle; every request is
// accepted at once (no back-pressure).
module atomic_mem_target #(
    parameter int AW    = 16,
    parameter int BASE  = 'h1000,
    parameter int DEPTH = 64,
    parameter int NREQ  = 4,
    parameter int CW    = 16,
    localparam int IDW  = $clog2(NREQ),
    localparam int OW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [2:0]     req_cmd,
    input  logic [AW-1:0]  req_addr,
    input  logic [3:0]     req_size,
    input  logic [63:0]    req_wdata,
    input  logic [63:0]    req_cmp,
    input  logic [IDW-1:0] req_id,
    input  logic           req_ifetch,
    input  logic           req_needs_resp,
    input  logic           req_cache_resp,
    input  logic           wr_allow,
    input  logic [IDW-1:0] stat_sel,
    output logic           rsp_valid,
    output logic [63:0]    rsp_rdata,
    output logic           err_flag,
    output logic [CW-1:0]  stat_rd_cnt,
    output logic [CW-1:0]  stat_wr_cnt,
    output logic [CW-1:0]  stat_oth_cnt,
    output logic [CW-1:0]  stat_rd_bytes,
    output logic [CW-1:0]  stat_wr_bytes,
    output logic [CW-1:0]  stat_if_bytes
);
    logic [OW-1:0] off;
    logic [63:0]   old_data;
    logic mem_wr, ret_old, resp, err_set, inc_rd, inc_wr, inc_oth;

    amt_decode #(.AW(AW), .BASE(BASE), .DEPTH(DEPTH)) u_dec (
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_size(req_size), .req_cmp(req_cmp), .req_needs_resp(req_needs_resp),
        .req_cache_resp(req_cache_resp), .wr_allow(wr_allow), .old_data(old_data),
        .off(off), .mem_wr(mem_wr), .ret_old(ret_old), .resp(resp),
        .err_set(err_set), .inc_rd(inc_rd), .inc_wr(inc_wr), .inc_oth(inc_oth)
    );

    amt_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .off(off), .size(req_size), .wr_en(mem_wr),
        .wdata(req_wdata), .rdata(old_data)
    );

    amt_stats #(.NREQ(NREQ), .CW(CW)) u_stats (
        .clk(clk), .rst_n(rst_n), .id(req_id), .inc_rd(inc_rd),
        .inc_wr(inc_wr), .inc_oth(inc_oth), .ifetch(req_ifetch),
        .size(req_size), .sel(stat_sel),
        .rd_cnt(stat_rd_cnt), .wr_cnt(stat_wr_cnt), .oth_cnt(stat_oth_cnt),
        .rd_bytes(stat_rd_bytes), .wr_bytes(stat_wr_bytes), .if_bytes(stat_if_bytes)
    );

    // Response register: strobe plus old data or zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= resp;
            rsp_rdata <= (resp && ret_old) ? old_data : 64'h0;
        end
    end

    // Sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_flag <= 1'b0;
        else if (err_set) err_flag <= 1'b1;
    end
endmodule

// File: rtl/amt_checker.sv
// Port-level protocol checker for atomic_mem_target, attached by bind.
module amt_checker #(
    parameter int AW  = 16,
    parameter int IDW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_cmd,
    input logic          req_needs_resp,
    input logic          req_cache_resp,
    input logic          rsp_valid,
    input logic [63:0]   rsp_rdata,
    input logic          err_flag
);
    assert_cache_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cache_resp) |=> !rsp_valid);

    assert_no_unrequested_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_needs_resp) |=> !rsp_valid);

    assert_evict_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_cmd == 3'd5 || req_cmd == 3'd6)) |=> !rsp_valid);

    assert_inval_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_cache_resp && req_cmd == 3'd4) |=> (rsp_rdata == 64'h0));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_unknown_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_cache_resp && req_cmd == 3'd7) |=> (err_flag && !rsp_valid));
endmodule

bind atomic_mem_target amt_checker #(.AW(AW), .IDW(IDW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_needs_resp(req_needs_resp), .req_cache_resp(req_cache_resp),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_flag(err_flag)
);

// File: tb/atomic_mem_target_bench.sv
module atomic_mem_target_bench;
    localparam int AW = 16, BASE = 'h1000, DEPTH = 64, NREQ = 4, CW = 16, IDW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_ifetch = 0, req_needs_resp = 0, req_cache_resp = 0, wr_allow = 0;
    logic [2:0] req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0] req_size = '0;
    logic [63:0] req_wdata = '0, req_cmp = '0;
    logic [IDW-1:0] req_id = '0, stat_sel = '0;
    logic rsp_valid, err_flag;
    logic [63:0] rsp_rdata;
    logic [CW-1:0] s_rc, s_wc, s_oc, s_rb, s_wb, s_ib;

    atomic_mem_target #(.AW(AW), .BASE(BASE), .DEPTH(DEPTH), .NREQ(NREQ), .CW(CW)) u_atomic_mem_target (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_cmp(req_cmp), .req_id(req_id), .req_ifetch(req_ifetch),
        .req_needs_resp(req_needs_resp), .req_cache_resp(req_cache_resp),
        .wr_allow(wr_allow), .stat_sel(stat_sel), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .err_flag(err_flag), .stat_rd_cnt(s_rc),
        .stat_wr_cnt(s_wc), .stat_oth_cnt(s_oc), .stat_rd_bytes(s_rb),
        .stat_wr_bytes(s_wb), .stat_if_bytes(s_ib)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] mm [DEPTH];
    int e_rc [NREQ], e_wc [NREQ], e_oc [NREQ], e_rb [NREQ], e_wb [NREQ], e_ib [NREQ];
    bit e_err = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [95:0] stats_exp(input int id);
        return {CW'(e_rc[id]), CW'(e_wc[id]), CW'(e_oc[id]), CW'(e_rb[id]), CW'(e_wb[id]), CW'(e_ib[id])};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        e_err = 0;
        for (int r = 0; r < NREQ; r++) begin
            e_rc[r] = 0; e_wc[r] = 0; e_oc[r] = 0; e_rb[r] = 0; e_wb[r] = 0; e_ib[r] = 0;
        end
    endtask

    // One request: model the expected outcome, drive at a falling edge,
    // sample at the next falling edge.
    task automatic xact(input logic [2:0] c, input logic [15:0] a, input logic [3:0] sz,
                        input logic [63:0] wd, input logic [63:0] cmp, input logic [1:0] id,
                        input bit ifc, input bit nr, input bit cr, input bit al, input string tag);
        logic [63:0] old, msk, exp_d;
        bit drop, ok, match, wr, exp_v;
        int off;
        old = '0; msk = '0; ok = 0;
        drop = cr || c == 3'd5 || c == 3'd6;
        off = int'(a) - BASE;
        if (!drop) begin
            ok = (c != 3'd7) && sz >= 4'd1 && sz <= 4'd8 && int'(a) >= BASE &&
                 (off + int'(sz)) <= DEPTH && (c != 3'd3 || sz == 4'd4 || sz == 4'd8);
            if (!ok) e_err = 1;
        end
        if (ok) for (int i = 0; i < int'(sz); i++) begin
            old[8*i +: 8] = mm[off + i];
            msk[8*i +: 8] = 8'hff;
        end
        match = (old == (cmp & msk));
        wr = ok && ((c == 3'd1 && al) || c == 3'd2 || (c == 3'd3 && match));
        exp_v = ok && nr;
        exp_d = (c == 3'd0 || c == 3'd2 || c == 3'd3) ? old : 64'h0;
        if (ok) begin
            if (c == 3'd0) begin
                e_rc[id]++; e_rb[id] += int'(sz);
                if (ifc) e_ib[id] += int'(sz);
            end
            if (c == 3'd1 && al) begin e_wc[id]++; e_wb[id] += int'(sz); end
            if (c == 3'd2 || c == 3'd3) e_oc[id]++;
        end
        req_valid = 1; req_cmd = c; req_addr = a; req_size = sz; req_wdata = wd;
        req_cmp = cmp; req_id = id; req_ifetch = ifc; req_needs_resp = nr;
        req_cache_resp = cr; wr_allow = al; stat_sel = id;
        @(negedge clk);
        req_valid = 0;
        if (wr) for (int i = 0; i < int'(sz); i++) mm[off + i] = wd[8*i +: 8];
        chk(rsp_valid == exp_v, {tag, " rsp_valid"}, 128'(rsp_valid), 128'(exp_v));
        if (exp_v) chk(rsp_rdata == exp_d, {tag, " rsp_rdata"}, 128'(rsp_rdata), 128'(exp_d));
        chk(err_flag == e_err, {tag, " err_flag"}, 128'(err_flag), 128'(e_err));
        chk({s_rc, s_wc, s_oc, s_rb, s_wb, s_ib} == stats_exp(id), {tag, " stats R10"},
            128'({s_rc, s_wc, s_oc, s_rb, s_wb, s_ib}), 128'(stats_exp(id)));
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    localparam logic [15:0] B = 16'(BASE);

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk(rsp_valid == 0 && err_flag == 0, "R1 reset outputs", 128'({rsp_valid, err_flag}), 128'(0));
        for (int r = 0; r < NREQ; r++) begin
            stat_sel = 2'(r); #1;
            chk({s_rc, s_wc, s_oc, s_rb, s_wb, s_ib} == 96'h0, "R1 counters", 128'({s_rc, s_wc, s_oc, s_rb, s_wb, s_ib}), 128'(0));
        end
        @(negedge clk);
        // R3: fill memory with allowed 8-byte writes
        for (int k = 0; k < DEPTH / 8; k++)
            xact(3'd1, B + 16'(8*k), 4'd8, {8{8'(k)}} ^ 64'h0706050403020100, '0, 2'd0, 0, 1, 0, 1, "R3 fill");
        // R2: reads of several sizes and the last byte
        xact(3'd0, B + 16'd3, 4'd1, '0, '0, 2'd1, 0, 1, 0, 0, "R2 read1");
        xact(3'd0, B + 16'd6, 4'd4, '0, '0, 2'd1, 0, 1, 0, 0, "R2 read4 cross");
        xact(3'd0, B + 16'(DEPTH - 8), 4'd8, '0, '0, 2'd1, 0, 1, 0, 0, "R2 read8 top");
        xact(3'd0, B + 16'(DEPTH - 1), 4'd1, '0, '0, 2'd1, 0, 1, 0, 0, "R2 last byte");
        // R3: write denied by monitor
        xact(3'd1, B + 16'd8, 4'd4, 64'hdeadbeef, '0, 2'd2, 0, 1, 0, 0, "R3 denied");
        xact(3'd0, B + 16'd8, 4'd4, '0, '0, 2'd2, 0, 1, 0, 0, "R3 denied readback");
        // R4: plain swap then readback
        xact(3'd2, B + 16'd16, 4'd2, 64'h0000_0000_0000_abcd, '0, 2'd3, 0, 1, 0, 0, "R4 swap");
        xact(3'd0, B + 16'd16, 4'd2, '0, '0, 2'd3, 0, 1, 0, 0, "R4 readback");
        // R5: conditional swap match and mismatch
        xact(3'd3, B + 16'd24, 4'd4, 64'h1111_2222, {32'hffff_ffff, mm[27], mm[26], mm[25], mm[24]}, 2'd3, 0, 1, 0, 0, "R5 cswap match");
        xact(3'd0, B + 16'd24, 4'd4, '0, '0, 2'd3, 0, 1, 0, 0, "R5 match readback");
        xact(3'd3, B + 16'd32, 4'd8, 64'h5555, 64'h1, 2'd3, 0, 1, 0, 0, "R5 cswap mismatch");
        xact(3'd0, B + 16'd32, 4'd8, '0, '0, 2'd3, 0, 1, 0, 0, "R5 mismatch readback");
        // R6: cache responding write and unknown command are ignored
        xact(3'd1, B + 16'd40, 4'd8, 64'h0, '0, 2'd0, 0, 1, 1, 1, "R6 cache write");
        xact(3'd7, B, 4'd1, '0, '0, 2'd0, 0, 1, 1, 1, "R6 cache bad cmd");
        xact(3'd0, B + 16'd40, 4'd8, '0, '0, 2'd0, 0, 1, 0, 0, "R6 readback");
        // R7: evict notices
        xact(3'd5, B + 16'd40, 4'd8, 64'h0, '0, 2'd0, 0, 1, 0, 1, "R7 clean evict");
        xact(3'd6, B + 16'd40, 4'd8, 64'h0, '0, 2'd0, 0, 1, 0, 1, "R7 wb clean");
        xact(3'd5, 16'h0, 4'd0, 64'h0, '0, 2'd0, 0, 1, 0, 1, "R7 evict bad addr");
        // R8: invalidate
        xact(3'd4, B + 16'd40, 4'd8, 64'h0, '0, 2'd1, 0, 1, 0, 1, "R8 inval");
        xact(3'd0, B + 16'd40, 4'd8, '0, '0, 2'd1, 0, 1, 0, 0, "R8 readback");
        // R9: no response wanted, effect still happens
        xact(3'd1, B + 16'd48, 4'd2, 64'h9999, '0, 2'd2, 0, 0, 0, 1, "R9 silent write");
        xact(3'd0, B + 16'd48, 4'd2, '0, '0, 2'd2, 0, 0, 0, 0, "R9 silent read");
        xact(3'd0, B + 16'd48, 4'd2, '0, '0, 2'd2, 0, 1, 0, 0, "R9 readback");
        // R10: instruction fetch bytes
        xact(3'd0, B + 16'd4, 4'd4, '0, '0, 2'd1, 1, 1, 0, 0, "R10 ifetch");
        // R11, R12, R5 error cases, each from a clean reset
        xact(3'd7, B, 4'd1, '0, '0, 2'd0, 0, 1, 0, 1, "R11 unknown cmd");
        xact(3'd0, B, 4'd1, '0, '0, 2'd0, 0, 1, 0, 0, "R11 sticky");
        do_reset();
        xact(3'd1, B + 16'(DEPTH - 2), 4'd4, 64'h0, '0, 2'd0, 0, 1, 0, 1, "R12 past top");
        do_reset();
        xact(3'd0, B - 16'd1, 4'd1, '0, '0, 2'd0, 0, 1, 0, 0, "R12 below base");
        do_reset();
        xact(3'd0, B, 4'd9, '0, '0, 2'd0, 0, 1, 0, 0, "R12 size 9");
        do_reset();
        xact(3'd3, B + 16'd8, 4'd2, 64'h0, '0, 2'd0, 0, 1, 0, 0, "R5 cswap bad size");
        xact(3'd0, B + 16'd8, 4'd4, '0, '0, 2'd0, 0, 1, 0, 0, "R5 bad size readback");
        do_reset();
        // Constrained random mix (R2..R12)
        for (int n = 0; n < 600; n++) begin
            int r, sel_sz;
            logic [2:0] c;
            logic [3:0] sz;
            logic [15:0] a;
            logic [63:0] cmp;
            r = int'($urandom % 16);
            c = (r < 5) ? 3'd0 : (r < 9) ? 3'd1 : (r < 11) ? 3'd2 : (r < 13) ? 3'd3 :
                (r == 13) ? 3'd4 : (r == 14) ? 3'(5 + $urandom % 2) : 3'd7;
            if (c == 3'd7 && ($urandom % 4) != 0) c = 3'd0;
            sel_sz = int'($urandom % 7);
            sz = (sel_sz < 2) ? 4'd4 : (sel_sz < 4) ? 4'd8 : (sel_sz == 4) ? 4'd1 :
                 (sel_sz == 5) ? 4'd2 : 4'd3;
            a = B + 16'($urandom % (DEPTH - 7));
            if (($urandom % 40) == 0) a = B + 16'(DEPTH - 2);
            cmp = {$urandom, $urandom};
            if ($urandom % 2 == 0 && int'(a) - BASE + 8 <= DEPTH)
                for (int i = 0; i < 8; i++) cmp[8*i +: 8] = mm[int'(a) - BASE + i];
            xact(c, a, sz, {$urandom, $urandom}, cmp, 2'($urandom % 4),
                 1'($urandom % 2), ($urandom % 5) != 0, ($urandom % 10) == 0,
                 ($urandom % 4) != 0, "R2-mix random");
            if (($urandom % 150) == 0) do_reset();
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule